// File: doc/BRIEF.md
# Exclusive Two-Level Victim Cache

This block is a small two-level data cache for a single core. The first level is a 2-way set-associative array. The second level is a 4-way victim store that receives nothing except lines pushed out of the first level. The two levels never hold the same line. When the first level misses and the second level hits, the line moves up and leaves the second level. When both levels miss, the line comes straight from the next-level memory into the first level. The block is write-back at both levels, and a modified line keeps its dirty state as it moves between them.

The core sends one word-addressed load or store at a time. It waits for a single response pulse that carries the load data or confirms the store. The memory side moves whole lines. A request line is held with its address, direction and data until the memory returns a one-cycle acknowledge.

Top module: `xvc_cache`

## Requirements
- R1: A line address is never valid in both levels at the same time.
- R2: A line fetched from memory is installed only in the first level. The second-level contents do not change on a memory fill.
- R3: A first-level miss that hits in the second level moves the line into the first level and invalidates its second-level entry in the same clock edge. A repeat access to that line then hits in the first level.
- R4: A miss in both levels issues exactly one memory read (`mem_we`=0) of the request's line address, which is the word address without its low log2(LINE_WORDS) bits. Address, direction and data stay stable until `mem_ack`.
- R5: First-level replacement is true LRU per set. The way not touched by the most recent access in the set is the one replaced.
- R6: The second level replaces by a 3-bit tree pseudo-LRU per set. An invalid way, lowest index first, is used before any valid way. A touched way w sets the root to point at the other half and sets the leaf of its half to point at its sibling.
- R7: A second-level victim goes to memory as a line write (`mem_we`=1) only when it is dirty. A clean victim is dropped with no memory traffic.
- R8: A first-level hit, load or store, raises `resp_valid` in the third cycle after the cycle in which the request is accepted. No response is ever faster.
- R9: A second-level hit raises `resp_valid` L2_EXTRA (default 9) cycles later than a first-level hit would.
- R10: Only one request is in flight. `req_ready` is high after reset and drops from acceptance until the response cycle has passed.
- R11: A store marks its line dirty. The dirty state moves with the line between levels, so data stored earlier reaches memory and is read back after the line leaves the cache.
- R12: When a second-level hit frees a way and the move displaces a valid first-level line, that line goes into the freed way. The swap causes no memory traffic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Core request present |
| req_ready | output | 1 | Block idle; request taken when both are high |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | WORD_W | Store data |
| resp_valid | output | 1 | One-cycle response pulse |
| resp_rdata | output | WORD_W | Load data, valid with resp_valid |
| mem_req | output | 1 | Line transfer requested |
| mem_we | output | 1 | 1 = line write-back, 0 = line read |
| mem_addr | output | ADDR_W-log2(LINE_WORDS) | Line address |
| mem_wdata | output | WORD_W*LINE_WORDS | Line written back |
| mem_ack | input | 1 | One-cycle completion of the transfer |
| mem_rdata | input | WORD_W*LINE_WORDS | Line read, valid with mem_ack |

## Verification
Two operations can land on one clock edge. The first is the move of a second-level hit into the first level, and the second is the push of the displaced first-level line into the way that move frees. The bench sets this up by filling one set with three lines, so that the line it asks for sits in the second level while the first-level LRU way holds a valid line. It then checks two things: the response arrives after the second-level latency with no memory traffic, and a later request for the displaced line is itself a second-level hit. The memory write-back of a dirty second-level victim comes just before the fill that replaces it. This is judged from the order of memory transfers, from which line the pseudo-LRU picks, and from the stored word read back after the line has left the cache.

// File: rtl/xvc_cache.sv
module xvc_cache #(
  parameter int ADDR_W     = 12,
  parameter int WORD_W     = 32,
  parameter int LINE_WORDS = 4,
  parameter int L1_SETS    = 4,
  parameter int L2_SETS    = 2,
  parameter int L2_EXTRA   = 9
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               req_valid,
  output logic                               req_ready,
  input  logic                               req_write,
  input  logic [ADDR_W-1:0]                  req_addr,
  input  logic [WORD_W-1:0]                  req_wdata,
  output logic                               resp_valid,
  output logic [WORD_W-1:0]                  resp_rdata,
  output logic                               mem_req,
  output logic                               mem_we,
  output logic [ADDR_W-$clog2(LINE_WORDS)-1:0] mem_addr,
  output logic [WORD_W*LINE_WORDS-1:0]       mem_wdata,
  input  logic                               mem_ack,
  input  logic [WORD_W*LINE_WORDS-1:0]       mem_rdata
);
  localparam int OFF_W  = $clog2(LINE_WORDS);
  localparam int LA_W   = ADDR_W - OFF_W;
  localparam int LINE_W = WORD_W * LINE_WORDS;
  localparam int I1_W   = $clog2(L1_SETS);
  localparam int I2_W   = $clog2(L2_SETS);
  localparam int N1     = L1_SETS * 2;
  localparam int N2     = L2_SETS * 4;
  localparam int CNT_W  = $clog2(L2_EXTRA + 1);

  typedef enum logic [2:0] {S_IDLE, S_LOOK, S_WB, S_FILL, S_WAIT, S_RESP} st_t;

  function automatic logic [2:0] plru_touch(input logic [2:0] b, input logic [1:0] w);
    logic [2:0] n;
    n = b;
    n[0] = ~w[1];
    if (!w[1]) n[1] = ~w[0];
    else       n[2] = ~w[0];
    return n;
  endfunction

  function automatic logic [1:0] plru_pick(input logic [2:0] b);
    return b[0] ? {1'b1, b[2]} : {1'b0, b[1]};
  endfunction

  st_t                st;
  logic               op_we;
  logic [ADDR_W-1:0]  op_addr;
  logic [WORD_W-1:0]  op_wd, rdata_q;
  logic [N1-1:0]      l1_v, l1_d;
  logic [LA_W-1:0]    l1_tag [N1];
  logic [LINE_W-1:0]  l1_data [N1];
  logic [L1_SETS-1:0] lru1;
  logic [N2-1:0]      l2_v, l2_d;
  logic [LA_W-1:0]    l2_tag [N2];
  logic [LINE_W-1:0]  l2_data [N2];
  logic [2:0]         plru [L2_SETS];
  logic               way_q;
  logic [1:0]         t2_q;
  logic [CNT_W-1:0]   cnt;

  wire [LA_W-1:0]  op_la = op_addr[ADDR_W-1:OFF_W];
  wire [I1_W-1:0]  s1    = op_la[I1_W-1:0];
  wire [I2_W-1:0]  s2    = op_la[I2_W-1:0];
  wire [OFF_W-1:0] wsel  = op_addr[OFF_W-1:0];

  logic [1:0] hit1;
  logic [3:0] hit2;
  logic [1:0] h2way, t2way;

  always_comb begin
    hit1  = '0;
    hit2  = '0;
    h2way = '0;
    t2way = plru_pick(plru[s2]);
    for (int w = 0; w < 2; w++)
      hit1[w] = l1_v[{s1, w[0]}] && (l1_tag[{s1, w[0]}] == op_la);
    for (int w = 0; w < 4; w++) begin
      hit2[w] = l2_v[{s2, w[1:0]}] && (l2_tag[{s2, w[1:0]}] == op_la);
      if (hit2[w]) h2way = w[1:0];
    end
    for (int w = 3; w >= 0; w--)
      if (!l2_v[{s2, w[1:0]}]) t2way = w[1:0];
  end

  wire               vw  = lru1[s1];
  wire [I1_W:0]      iv  = {s1, vw};
  wire [I1_W:0]      iq  = {s1, way_q};
  wire [I2_W+1:0]    ih  = {s2, h2way};
  wire [I2_W+1:0]    it  = {s2, t2way};
  wire [I2_W+1:0]    itq = {s2, t2_q};

  assign req_ready  = (st == S_IDLE);
  assign resp_valid = (st == S_RESP);
  assign resp_rdata = rdata_q;
  assign mem_req    = (st == S_WB) || (st == S_FILL);
  assign mem_we     = (st == S_WB);
  assign mem_addr   = mem_we ? l2_tag[itq] : op_la;
  assign mem_wdata  = l2_data[itq];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      l1_v    <= '0;
      l1_d    <= '0;
      l2_v    <= '0;
      l2_d    <= '0;
      lru1    <= '0;
      for (int s = 0; s < L2_SETS; s++) plru[s] <= '0;
      way_q   <= 1'b0;
      t2_q    <= '0;
      cnt     <= '0;
      op_we   <= 1'b0;
      op_addr <= '0;
      op_wd   <= '0;
      rdata_q <= '0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          op_we   <= req_write;
          op_addr <= req_addr;
          op_wd   <= req_wdata;
          st      <= S_LOOK;
        end
        S_LOOK: begin
          if (|hit1) begin
            way_q <= hit1[1];
            cnt   <= '0;
            st    <= S_WAIT;
          end else if (|hit2) begin
            way_q       <= vw;
            l1_tag[iv]  <= op_la;
            l1_data[iv] <= l2_data[ih];
            l1_v[iv]    <= 1'b1;
            l1_d[iv]    <= l2_d[ih];
            if (l1_v[iv]) begin
              l2_tag[ih]  <= l1_tag[iv];
              l2_data[ih] <= l1_data[iv];
              l2_d[ih]    <= l1_d[iv];
              plru[s2]    <= plru_touch(plru[s2], h2way);
            end else begin
              l2_v[ih] <= 1'b0;
            end
            cnt <= CNT_W'(L2_EXTRA);
            st  <= S_WAIT;
          end else begin
            way_q <= vw;
            t2_q  <= t2way;
            if (l1_v[iv] && l2_v[it] && l2_d[it]) begin
              st <= S_WB;
            end else begin
              if (l1_v[iv]) begin
                l2_tag[it]  <= l1_tag[iv];
                l2_data[it] <= l1_data[iv];
                l2_d[it]    <= l1_d[iv];
                l2_v[it]    <= 1'b1;
                l1_v[iv]    <= 1'b0;
                plru[s2]    <= plru_touch(plru[s2], t2way);
              end
              st <= S_FILL;
            end
          end
        end
        S_WB: if (mem_ack) begin
          l2_tag[itq]  <= l1_tag[iq];
          l2_data[itq] <= l1_data[iq];
          l2_d[itq]    <= l1_d[iq];
          l2_v[itq]    <= 1'b1;
          l1_v[iq]     <= 1'b0;
          plru[s2]     <= plru_touch(plru[s2], t2_q);
          st           <= S_FILL;
        end
        S_FILL: if (mem_ack) begin
          l1_tag[iq]  <= op_la;
          l1_data[iq] <= mem_rdata;
          l1_v[iq]    <= 1'b1;
          l1_d[iq]    <= 1'b0;
          cnt         <= '0;
          st          <= S_WAIT;
        end
        S_WAIT: begin
          if (cnt == '0) begin
            rdata_q <= l1_data[iq][wsel*WORD_W +: WORD_W];
            if (op_we) begin
              l1_data[iq][wsel*WORD_W +: WORD_W] <= op_wd;
              l1_d[iq] <= 1'b1;
            end
            lru1[s1] <= ~way_q;
            st       <= S_RESP;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_RESP:  st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  logic dup;
  always_comb begin
    dup = 1'b0;
    for (int i = 0; i < N1; i++)
      for (int j = 0; j < N2; j++)
        if (l1_v[i] && l2_v[j] && (l1_tag[i] == l2_tag[j])) dup = 1'b1;
  end

  logic [3:0] lat_q;
  always_ff @(posedge clk) begin
    if (!rst_n)                      lat_q <= '0;
    else if (req_valid && req_ready) lat_q <= '0;
    else if (lat_q != 4'hF)          lat_q <= lat_q + 1'b1;
  end

  // R1
  excl_levels_chk: assert property (@(posedge clk) disable iff (!rst_n) !dup);

  // R2
  fill_skips_l2_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_FILL && mem_ack) |=> ($stable(l2_v) && $stable(l2_d)));

  // R3
  move_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_LOOK && hit1 == 2'b00 && hit2 != 4'b0000) |=> (hit1 != 2'b00 && hit2 == 4'b0000));

  // R4
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_addr)));

  // R7
  wb_dirty_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (l2_v[itq] && l2_d[itq]));

  // R8
  min_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> (lat_q >= 4'd2));

  // R10
  one_in_flight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R10
  busy_at_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> !req_ready);
endmodule

// File: tb/xvc_cache_tb.sv
module xvc_cache_tb;
  localparam int AW = 12;
  localparam int WW = 32;
  localparam int LA_W = 10;
  localparam int LINE_W = 128;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic              req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0]     req_addr = '0;
  logic [WW-1:0]     req_wdata = '0;
  logic              req_ready, resp_valid, mem_req, mem_we;
  logic [WW-1:0]     resp_rdata;
  logic [LA_W-1:0]   mem_addr;
  logic [LINE_W-1:0] mem_wdata;
  logic              mem_ack = 1'b0;
  logic [LINE_W-1:0] mem_rdata = '0;

  xvc_cache u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .resp_valid(resp_valid), .resp_rdata(resp_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  function automatic logic [31:0] pat(int a);
    return 32'h5A00_0000 ^ (32'(a) * 32'h0000_9E37);
  endfunction

  function automatic logic [127:0] pat_line(int la);
    logic [127:0] l;
    for (int w = 0; w < 4; w++) l[w*32 +: 32] = pat(la*4 + w);
    return l;
  endfunction

  // next-level memory model: 3-cycle acknowledge
  logic [127:0] wr_lines [int];
  int nrd = 0, nwr = 0, last_rd = -1, last_wr = -1, dly = 0;
  always @(posedge clk) begin
    if (!rst_n) begin
      mem_ack <= 1'b0;
      dly     <= 0;
    end else if (mem_ack) begin
      mem_ack <= 1'b0;
    end else if (mem_req) begin
      if (dly == 2) begin
        dly     <= 0;
        mem_ack <= 1'b1;
        if (mem_we) begin
          wr_lines[int'(mem_addr)] = mem_wdata;
          nwr     <= nwr + 1;
          last_wr <= int'(mem_addr);
        end else begin
          mem_rdata <= wr_lines.exists(int'(mem_addr)) ? wr_lines[int'(mem_addr)]
                                                       : pat_line(int'(mem_addr));
          nrd     <= nrd + 1;
          last_rd <= int'(mem_addr);
        end
      end else begin
        dly <= dly + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  logic [31:0] q_data [$];
  bit          q_wr   [$];
  int          q_lat  [$];
  int          q_t0   [$];
  int          q_rd0  [$];
  int          q_wr0  [$];
  int          q_erd  [$];
  int          q_ewr  [$];
  string       q_tag  [$];
  logic [31:0] ref_w  [int];

  // monitor: pops one expected item per response
  always @(negedge clk) begin
    if (rst_n && resp_valid) begin
      if (q_tag.size() == 0) begin
        chk(1'b0, "R10", "response with nothing outstanding", 1, 0);
      end else begin
        logic [31:0] d;
        bit wr;
        int lat, t0, rd0, wr0, erd, ewr;
        string tag;
        d = q_data.pop_front(); wr = q_wr.pop_front(); lat = q_lat.pop_front();
        t0 = q_t0.pop_front(); rd0 = q_rd0.pop_front(); wr0 = q_wr0.pop_front();
        erd = q_erd.pop_front(); ewr = q_ewr.pop_front(); tag = q_tag.pop_front();
        if (!wr) chk(resp_rdata == d, tag, "load data", resp_rdata, d);
        if (lat > 0) chk((cyc - t0) == lat, tag, "response latency", cyc - t0, lat);
        chk(req_ready == 1'b0, "R10", "ready low at response", req_ready, 0);
        if (erd < 0) chk(nrd == rd0, tag, "memory reads", nrd - rd0, 0);
        else begin
          chk(nrd == rd0 + 1, tag, "memory reads", nrd - rd0, 1);
          chk(last_rd == erd, tag, "memory read line", last_rd, erd);
        end
        if (ewr < 0) chk(nwr == wr0, tag, "memory writes", nwr - wr0, 0);
        else begin
          chk(nwr == wr0 + 1, tag, "memory writes", nwr - wr0, 1);
          chk(last_wr == ewr, tag, "memory write line", last_wr, ewr);
        end
      end
    end
  end

  // driver: pushes the expectation, then presents the request
  task automatic acc(input bit wr, input int addr, input logic [31:0] wd, input int lat,
                     input int erd, input int ewr, input string tag);
    logic [31:0] e;
    while (!req_ready) @(negedge clk);
    if (wr) ref_w[addr] = wd;
    e = ref_w.exists(addr) ? ref_w[addr] : pat(addr);
    q_data.push_back(e); q_wr.push_back(wr); q_lat.push_back(lat);
    q_t0.push_back(cyc); q_rd0.push_back(nrd); q_wr0.push_back(nwr);
    q_erd.push_back(erd); q_ewr.push_back(ewr); q_tag.push_back(tag);
    req_valid = 1'b1;
    req_write = wr;
    req_addr  = AW'(addr);
    req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    while (q_tag.size() != 0) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  // lines A..H share first-level set 0 and second-level set 0
  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R10", "ready after reset", req_ready, 1);
    chk(resp_valid == 1'b0, "R10", "no response after reset", resp_valid, 0);
    chk(mem_req == 1'b0, "R4", "no memory request after reset", mem_req, 0);

    acc(0,   0, 0,  0,  0, -1, "R4");   // A miss
    acc(0,   1, 0,  3, -1, -1, "R8");   // A hit
    acc(0,  16, 0,  0,  4, -1, "R4");   // B miss
    acc(0,   2, 0,  3, -1, -1, "R5");   // A hit, B becomes LRU
    acc(0,  32, 0,  0,  8, -1, "R4");   // C miss, B to L2
    acc(0,   3, 0,  3, -1, -1, "R5");   // A kept by LRU
    acc(0,  17, 0, 12, -1, -1, "R9");   // B from L2, C into freed way
    acc(0,  18, 0,  3, -1, -1, "R3/R1"); // B now first level only
    acc(0,  33, 0, 12, -1, -1, "R12");  // C was placed in freed way
    acc(1,  32, 32'hDEAD_0001, 3, -1, -1, "R8"); // store hit, C dirty
    acc(0,  48, 0,  0, 12, -1, "R4");   // D miss
    acc(0,  64, 0,  0, 16, -1, "R11");  // E miss, dirty C to L2, no write
    acc(0,  80, 0,  0, 20, -1, "R1");   // F miss, L2 set full
    acc(0,  96, 0,  0, 24, -1, "R7");   // G miss, clean A dropped
    acc(0, 112, 0,  0, 28,  8, "R6");   // H miss, pseudo-LRU picks dirty C
    acc(0,  32, 0,  0,  8, -1, "R11");  // stored word back from memory
    acc(0,   0, 0,  0,  0, -1, "R2");   // A only in memory
    acc(0, 114, 0, 12, -1, -1, "R9");   // H from L2

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule